// File: doc/BRIEF.md
# Grouped Interrupt Flag Controller

This block collects sixteen interrupt sources into four groups of four and drives one interrupt request line for each group. Each group has a flag register and an enable register. A flag bit latches on a rising edge of its source and stays set until software clears it. An enable bit decides whether that flag can raise the group's request line. The four request lines stand for four priority levels, from group 0 (lowest, level 3) to group 3 (highest, level 6). Each line is driven on its own, and the priority encoding is done by the interrupt controller that receives them.

Software reaches the registers over a simple byte-wide bus with an address, a write strobe, a read strobe and write and read data. The bus has no handshake. Every access completes in one cycle, and there is no back-pressure.

Flags are cleared by writing 1 to them. Enables are written in a set/clear style: bit 7 of the written byte chooses between setting and clearing the enable bits given as 1 in bits 3:0. The driver can therefore change one source without a read-modify-write. Writing 0x0F to every enable register and then to every flag register masks and clears every source.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: After reset, every flag and enable bit is 0 and all four request outputs are low. An active-low reset clears this state even while the clock is stopped.
- R2: A source input sets its flag bit in the clock edge where the input is first seen high after being low. The enable bit has no effect on this. A source held high does not set its flag again once the flag has been cleared.
- R3: A write to a flag register clears each flag bit whose write-data bit (3:0) is 1 and leaves the others unchanged.
- R4: If a source rises in the same cycle as a write that clears its flag bit, the flag stays set.
- R5: A write to an enable register with write-data bit 7 = 1 sets each enable bit whose write-data bit (3:0) is 1 and leaves the others unchanged.
- R6: A write to an enable register with write-data bit 7 = 0 clears each enable bit whose write-data bit (3:0) is 1 and leaves the others unchanged.
- R7: Write-data bits 6:4 have no effect. A read of an enable register returns bit 7 = 1, bits 6:4 = 0 and the enables in bits 3:0. A read of a flag register returns bits 7:4 = 0 and the flags in bits 3:0.
- R8: Request output bit g is high exactly when group g has a flag bit and its enable bit both set. Group g takes source inputs 4g+3..4g, with source 4g+i on bit i.
- R9: Group g's flag register is at address 0x30 + 0x10·g and its enable register at 0x34 + 0x10·g. Any other address reads 0 and ignores writes.
- R10: Read data is registered. A read strobe in one cycle places the addressed value on the read data port after that clock edge. Read data then holds, even if registers change, until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| src_i | input | 16 | Interrupt source inputs, four per group |
| irq_o | output | 4 | Per-group request lines, bit g for group g (levels 3 to 6) |

## Verification
The bench fires a source in the same cycle as a write that clears its flag. A design that lets the clear win would lose that event. It also holds a source high across a flag clear, which catches a design that latches levels instead of edges, because such a design would set the flag again at once. Enable writes with bit 7 both set and clear, and with junk in bits 6:4, expose a design that overwrites the enables or lets the padding bits leak into the read back. Finally, the bench writes to an unmapped address inside a group's window, checks that read data holds after a register changes underneath it, and asserts reset mid-run. These catch a decoder that is too loose, a read port that is not registered, and a reset that is not asynchronous.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_GRP     = 4;
  localparam int SRC_PER_GRP = 4;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int GRP_BASE    = 'h30;
  localparam int GRP_STRIDE  = 'h10;
  localparam int FLAG_OFS    = 'h0;
  localparam int EN_OFS      = 'h4;
  localparam int EN_MODE_BIT = 7;

  function automatic int reg_addr(int grp, int ofs);
    return GRP_BASE + grp * GRP_STRIDE + ofs;
  endfunction
endpackage

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = src_i[i] & ~src_q[i];
  end
endmodule

// File: rtl/intc_group.sv
module intc_group #(
  parameter int N       = 4,
  parameter int DATA_W  = 8,
  parameter int MODE_BT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      rise_i,
  input  logic              flag_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      flag_o,
  output logic [N-1:0]      en_o,
  output logic              irq_o
);
  logic [N-1:0] flag_q, en_q, clr_mask, bits;

  assign bits     = wdata_i[N-1:0];
  assign clr_mask = flag_wr_i ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | rise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_wr_i) begin
      if (wdata_i[MODE_BT]) en_q <= en_q | bits;
      else                  en_q <= en_q & ~bits;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = |(flag_q & en_q);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_i && rise_i == '0) |=> ((flag_q & $past(wdata_i[N-1:0])) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((flag_q & $past(rise_i)) == $past(rise_i)));

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && wdata_i[MODE_BT]) |=>
      ((en_q & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && !wdata_i[MODE_BT]) |=> ((en_q & $past(wdata_i[N-1:0])) == '0));

  p_en_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_q));
endmodule

// File: rtl/intc_regbus.sv
module intc_regbus
  import intc_pkg::*;
#(
  parameter int G = NUM_GRP,
  parameter int N = SRC_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [G*N-1:0]    flags_i,
  input  logic [G*N-1:0]    ens_i,
  output logic [G-1:0]      flag_wr_o,
  output logic [G-1:0]      en_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD = DATA_W - N;

  logic [G-1:0]      flag_sel, en_sel;
  logic [DATA_W-1:0] rd_mux, rd_q;

  for (genvar g = 0; g < G; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(reg_addr(g, FLAG_OFS));
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(reg_addr(g, EN_OFS));
    assign flag_sel[g]  = (addr_i == FA);
    assign en_sel[g]    = (addr_i == EA);
    assign flag_wr_o[g] = wr_en_i & flag_sel[g];
    assign en_wr_o[g]   = wr_en_i & en_sel[g];
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < G; g++) begin
      if (flag_sel[g]) rd_mux = rd_mux | {{PAD{1'b0}}, flags_i[g*N +: N]};
      if (en_sel[g]) begin
        rd_mux = rd_mux | {{PAD{1'b0}}, ens_i[g*N +: N]};
        rd_mux[EN_MODE_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rdata_o = rd_q;

  p_one_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_sel, en_sel}));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));

  p_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[6:4] == 3'b000);
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import intc_pkg::*;
#(
  parameter int G = NUM_GRP,
  parameter int N = SRC_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [G*N-1:0]    src_i,
  output logic [G-1:0]      irq_o
);
  localparam int NSRC = G * N;

  logic [NSRC-1:0] rise, flags, ens;
  logic [G-1:0]    flag_wr, en_wr;

  intc_edge #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
  );

  intc_regbus #(.G(G), .N(N)) u_bus (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .flags_i(flags), .ens_i(ens),
    .flag_wr_o(flag_wr), .en_wr_o(en_wr), .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < G; g++) begin : g_grp
    intc_group #(.N(N), .DATA_W(DATA_W), .MODE_BT(EN_MODE_BIT)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise[g*N +: N]),
      .flag_wr_i(flag_wr[g]), .en_wr_i(en_wr[g]), .wdata_i(wdata_i),
      .flag_o(flags[g*N +: N]), .en_o(ens[g*N +: N]), .irq_o(irq_o[g])
    );
  end

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ens == '0) |-> (irq_o == '0));

  p_no_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (irq_o == '0));
endmodule

// File: tb/sim_grouped_irq_ctrl.sv
module sim_grouped_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 35;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PL = 2'd2;

  // {op, addr, data/source mask, expected read, expected irq}
  localparam logic [37:0] VEC [NV] = '{
    {OP_RD, 8'h30, 16'h0000, 8'h00, 4'h0},  // R1
    {OP_RD, 8'h34, 16'h0000, 8'h80, 4'h0},  // R1 R7
    {OP_RD, 8'h60, 16'h0000, 8'h00, 4'h0},  // R1
    {OP_RD, 8'h64, 16'h0000, 8'h80, 4'h0},  // R1
    {OP_PL, 8'h00, 16'h0005, 8'h00, 4'h0},  // R2 masked
    {OP_RD, 8'h30, 16'h0000, 8'h05, 4'h0},  // R2
    {OP_WR, 8'h34, 16'h00F1, 8'h00, 4'h1},  // R5 R7
    {OP_RD, 8'h34, 16'h0000, 8'h81, 4'h1},  // R7
    {OP_WR, 8'h30, 16'h0001, 8'h00, 4'h0},  // R3
    {OP_RD, 8'h30, 16'h0000, 8'h04, 4'h0},  // R3
    {OP_WR, 8'h34, 16'h0084, 8'h00, 4'h1},  // R5
    {OP_WR, 8'h34, 16'h0004, 8'h00, 4'h0},  // R6
    {OP_RD, 8'h34, 16'h0000, 8'h81, 4'h0},  // R6
    {OP_PL, 8'h00, 16'h1000, 8'h00, 4'h0},  // R8
    {OP_WR, 8'h64, 16'h0081, 8'h00, 4'h8},  // R8
    {OP_PL, 8'h00, 16'h0020, 8'h00, 4'h8},  // R8
    {OP_WR, 8'h44, 16'h0082, 8'h00, 4'hA},  // R8
    {OP_RD, 8'h40, 16'h0000, 8'h02, 4'hA},  // R9
    {OP_WR, 8'h54, 16'h008F, 8'h00, 4'hA},  // R5
    {OP_PL, 8'h00, 16'h0F00, 8'h00, 4'hE},  // R8
    {OP_RD, 8'h50, 16'h0000, 8'h0F, 4'hE},  // R9
    {OP_WR, 8'h3C, 16'h00FF, 8'h00, 4'hE},  // R9 unmapped
    {OP_RD, 8'h3C, 16'h0000, 8'h00, 4'hE},  // R9
    {OP_WR, 8'h50, 16'h00F8, 8'h00, 4'hE},  // R3 R7
    {OP_RD, 8'h50, 16'h0000, 8'h07, 4'hE},  // R7
    {OP_WR, 8'h34, 16'h000F, 8'h00, 4'hE},  // R6
    {OP_WR, 8'h44, 16'h000F, 8'h00, 4'hC},  // R6 R8
    {OP_WR, 8'h54, 16'h000F, 8'h00, 4'h8},  // R6
    {OP_WR, 8'h64, 16'h000F, 8'h00, 4'h0},  // R6
    {OP_WR, 8'h30, 16'h000F, 8'h00, 4'h0},  // R3
    {OP_WR, 8'h40, 16'h000F, 8'h00, 4'h0},  // R3
    {OP_WR, 8'h50, 16'h000F, 8'h00, 4'h0},  // R3
    {OP_WR, 8'h60, 16'h000F, 8'h00, 4'h0},  // R3
    {OP_RD, 8'h40, 16'h0000, 8'h00, 4'h0},  // R3
    {OP_RD, 8'h64, 16'h0000, 8'h80, 4'h0}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] src = '0;
  logic [3:0]  irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grouped_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .src_i(src), .irq_o(irq)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(logic [15:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R1 irq in reset", {4'h0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][37:36])
        OP_WR: wr(VEC[i][35:28], VEC[i][19:12]);
        OP_RD: begin
          rd(VEC[i][35:28]);
          check8($sformatf("R7/R9 read row %0d", i), rdata, VEC[i][11:4]);
        end
        default: pulse(VEC[i][27:12]);
      endcase
      check8($sformatf("R8 irq row %0d", i), {4'h0, irq}, {4'h0, VEC[i][3:0]});
    end

    // R2: level held high sets only once
    @(negedge clk); src[4] = 1'b1;
    @(negedge clk);
    rd(8'h40); check8("R2 held source latched", rdata, 8'h01);
    wr(8'h40, 8'h01);
    rd(8'h40); check8("R2 held source not relatched", rdata, 8'h00);
    @(negedge clk); src[4] = 1'b0;

    // R4: rise and clear in same cycle
    @(negedge clk); src[8] = 1'b1; addr = 8'h50; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; src[8] = 1'b0;
    rd(8'h50); check8("R4 set beats clear", rdata, 8'h01);

    // R10: read data holds without a read strobe
    wr(8'h50, 8'h01);
    repeat (2) @(negedge clk);
    check8("R10 read data holds", rdata, 8'h01);
    rd(8'h50); check8("R10 new read", rdata, 8'h00);

    // R1: mid-run asynchronous reset
    wr(8'h34, 8'h81);
    pulse(16'h0001);
    check8("R8 group0 request", {4'h0, irq}, 8'h01);
    #(CLK_PERIOD/4); rst_n = 1'b0; #1;
    check8("R1 async reset irq", {4'h0, irq}, 8'h00);
    check8("R1 async reset rdata", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h30); check8("R1 flag after reset", rdata, 8'h00);
    rd(8'h34); check8("R1 enable after reset", rdata, 8'h80);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule